// File: doc/BRIEF.md
# Multi-Lane 8b/10b Line Encoder with Disparity Override

This block turns 1, 2 or 4 bytes per clock into 10-bit transmission code groups using the classic 5b/6b plus 3b/4b split. Every byte lane carries its own control-character select, so a word can mix data and control characters freely. The running disparity moves through the lanes from the lowest byte to the highest inside one cycle, and the value left by the top lane is held for the next cycle.

Each lane can also ignore the running disparity and start its code group from a chosen polarity. A high override value selects a negative start and a low value selects a positive start. The chain then carries on from what that forced group actually leaves behind. A control-character request for a byte that has no legal control encoding raises a flag for that lane, and the byte goes out as a data character. All outputs are registered, so results appear one clock after the inputs.

Top module: `enc8b10b_lanes`

## Requirements
- R1: While `rst` is high, every code group and every flag reads zero on the clock after. The stored running disparity is set to negative, so the first group after reset is encoded from negative disparity.
- R2: Results for the inputs sampled at a rising edge appear at that edge and not before. Outputs have exactly one cycle of latency.
- R3: Lane i takes `data_i[8i+7:8i]`, with x = bits [4:0] and y = bits [7:5]. It drives `code_o[10i+9:10i]` in the order a,b,c,d,e,i,f,g,h,j from bit 10i+9 down to bit 10i. Bit a goes first on the line. Data characters follow the standard Dx.y tables: for example D21.5 is 0x2AA, and D0.0 from negative disparity is 0x274.
- R4: A balanced sub-block leaves the running disparity unchanged, and an unbalanced one inverts it. A code group started from negative disparity holds 5 or 6 ones, and one started from positive disparity holds 4 or 5 ones.
- R5: Lane i+1 starts from the ending disparity of lane i. The ending disparity of the top lane is stored for the next cycle. Four K28.5 characters from negative disparity give 0x0FA, 0x305, 0x0FA, 0x305 from lane 0 upward.
- R6: When `frc_i[i]`=1 and `fval_i[i]`=1, lane i starts from negative disparity, whatever the running value is.
- R7: When `frc_i[i]`=1 and `fval_i[i]`=0, lane i starts from positive disparity. K28.5 then encodes as 0x305.
- R8: After a forced lane, the chain continues from the actual ending disparity of that lane. It does not return to the value it had before the override.
- R9: With `ctl_i[i]`=1, the bytes K28.0–K28.7 (x=28) and K23.7, K27.7, K29.7, K30.7 (0xF7, 0xFB, 0xFD, 0xFE) encode as control characters. K28.5 is 0x0FA from negative disparity and 0x305 from positive disparity.
- R10: With `ctl_i[i]`=1 and any other byte, `bad_ctl_o[i]` is 1 and the lane outputs the data encoding of that byte. 0xFF from positive disparity gives 0x14E.
- R11: For y=7 in a data character, the alternate 0111/1000 sub-block is used in these cases: x is 17, 18 or 20 and the disparity is negative, or x is 11, 13 or 14 and the disparity is positive. It is always used for a control character with y=7. D17.7 from negative disparity is 0x237.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | LANES*8 | Bytes to encode, lane 0 in the low byte |
| ctl_i | input | LANES | Per-lane control-character select |
| frc_i | input | LANES | Per-lane disparity override enable |
| fval_i | input | LANES | Per-lane override value, 1 = negative start |
| code_o | output | LANES*10 | Registered code groups, lane 0 in the low 10 bits |
| bad_ctl_o | output | LANES | Registered flag for an illegal control byte |

## Verification
The bench drives all 256 data bytes from both disparities, every legal control character, and illegal control bytes. It follows these with long random runs that mix overrides of both polarities in every lane position. A design that chains lanes in the wrong order, or that returns to the pre-override disparity after a forced lane, leaves every later group in the word or the next cycle off by one polarity. A missing alternate x.7 rule shows up as wrong codes for D17.7, D11.7 and their relatives. Getting the K28 balanced sub-block wrong damages K28.1, K28.2, K28.5 and K28.6 from one of the two starting polarities. Fixed literal code values for K28.5, D21.5, D17.7, D0.0 and 0xFF pin down the bit order without depending on the bench model.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 10;

  // legal control characters: K28.y and K23/27/29/30.7
  function automatic logic ctl_char_ok(input logic [7:0] b);
    logic [4:0] x;
    x = b[4:0];
    return (x == 5'd28) ||
           ((b[7:5] == 3'b111) &&
            (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction

  // alternate x.7 selection for data characters, given the disparity after 5b/6b
  function automatic logic alt7_data(input logic [4:0] x, input logic mid_neg);
    return mid_neg ? (x == 5'd17 || x == 5'd18 || x == 5'd20)
                   : (x == 5'd11 || x == 5'd13 || x == 5'd14);
  endfunction
endpackage

// File: rtl/enc_sb6.sv
module enc_sb6 (
  input  logic [4:0] x_i,
  input  logic       k28_i,
  input  logic       neg_i,
  output logic [5:0] code_o,
  output logic       neg_o
);
  logic [5:0] base;
  logic       unbal;
  logic       keep;

  always_comb begin
    case (x_i)
      5'd0:  base = 6'b100111;  5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;  5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;  5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;  5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;  5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;  5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;  5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;  5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;  5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;  5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;  5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;  5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;  5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;  5'd27: base = 6'b110110;
      5'd28: base = 6'b001110;  5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;  default: base = 6'b101011;
    endcase
    if (k28_i) base = 6'b001111;
    unbal  = ($countones(base) != 3);
    keep   = !unbal && (base != 6'b111000);
    code_o = (keep || neg_i) ? base : ~base;
    neg_o  = neg_i ^ unbal;
  end
endmodule

// File: rtl/enc_sb4.sv
module enc_sb4 (
  input  logic [2:0] y_i,
  input  logic       alt_i,
  input  logic       k28_i,
  input  logic       start_neg_i,
  input  logic       neg_i,
  output logic [3:0] code_o,
  output logic       neg_o
);
  logic [3:0] base;
  logic       unbal;
  logic       k_bal;

  always_comb begin
    case (y_i)
      3'd0: base = 4'b1011;  3'd1: base = 4'b1001;
      3'd2: base = 4'b0101;  3'd3: base = 4'b1100;
      3'd4: base = 4'b1101;  3'd5: base = 4'b1010;
      3'd6: base = 4'b0110;  default: base = 4'b1110;
    endcase
    if (alt_i) base = 4'b0111;
    unbal = ($countones(base) != 2);
    // balanced K28 groups follow the polarity the whole group started with
    k_bal = k28_i && !unbal && (y_i != 3'd3);
    if (k_bal)
      code_o = start_neg_i ? base : ~base;
    else if (unbal || y_i == 3'd3)
      code_o = neg_i ? base : ~base;
    else
      code_o = base;
    neg_o = neg_i ^ unbal;
  end
endmodule

// File: rtl/enc_lane.sv
module enc_lane
  import enc8b10b_pkg::*;
(
  input  logic [BYTE_W-1:0] dat_i,
  input  logic              ctl_i,
  input  logic              frc_i,
  input  logic              fval_i,
  input  logic              rd_neg_i,
  output logic [CODE_W-1:0] code_o,
  output logic              start_neg_o,
  output logic              rd_neg_o,
  output logic              bad_ctl_o
);
  logic       k_ok, k_eff, k28, mid_neg, alt;
  logic [5:0] c6;
  logic [3:0] c4;

  assign k_ok        = ctl_char_ok(dat_i);
  assign k_eff       = ctl_i && k_ok;
  assign bad_ctl_o   = ctl_i && !k_ok;
  assign k28         = k_eff && (dat_i[4:0] == 5'd28);
  assign start_neg_o = frc_i ? fval_i : rd_neg_i;

  enc_sb6 u_sb6 (
    .x_i(dat_i[4:0]), .k28_i(k28), .neg_i(start_neg_o),
    .code_o(c6), .neg_o(mid_neg)
  );

  assign alt = (dat_i[7:5] == 3'b111) && (k_eff || alt7_data(dat_i[4:0], mid_neg));

  enc_sb4 u_sb4 (
    .y_i(dat_i[7:5]), .alt_i(alt), .k28_i(k28), .start_neg_i(start_neg_o),
    .neg_i(mid_neg), .code_o(c4), .neg_o(rd_neg_o)
  );

  assign code_o = {c6, c4};
endmodule

// File: rtl/enc8b10b_lanes.sv
module enc8b10b_lanes
  import enc8b10b_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*BYTE_W-1:0]   data_i,
  input  logic [LANES-1:0]          ctl_i,
  input  logic [LANES-1:0]          frc_i,
  input  logic [LANES-1:0]          fval_i,
  output logic [LANES*CODE_W-1:0]   code_o,
  output logic [LANES-1:0]          bad_ctl_o
);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int OUT_W  = LANES * CODE_W;

  initial assert (LANES == 1 || LANES == 2 || LANES == 4)
    else $error("LANES must be 1, 2 or 4");

  logic [LANES:0]      rd_chain;
  logic [CODE_W-1:0]   lane_code [LANES];
  logic [LANES-1:0]    lane_start_neg;
  logic [LANES-1:0]    lane_bad;
  logic [OUT_W-1:0]    code_d;
  logic                rd_q;

  assign rd_chain[0] = rd_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    enc_lane u_lane (
      .dat_i      (data_i[i*BYTE_W +: BYTE_W]),
      .ctl_i      (ctl_i[i]),
      .frc_i      (frc_i[i]),
      .fval_i     (fval_i[i]),
      .rd_neg_i   (rd_chain[i]),
      .code_o     (lane_code[i]),
      .start_neg_o(lane_start_neg[i]),
      .rd_neg_o   (rd_chain[i+1]),
      .bad_ctl_o  (lane_bad[i])
    );
    assign code_d[i*CODE_W +: CODE_W] = lane_code[i];

    // group weight must match its starting polarity
    AST_GROUP_WEIGHT: assert property (@(posedge clk) disable iff (rst)
      lane_start_neg[i] ? ($countones(lane_code[i]) inside {5, 6})
                        : ($countones(lane_code[i]) inside {4, 5})); // R4
    AST_FLAG_NEEDS_CTL: assert property (@(posedge clk) disable iff (rst)
      bad_ctl_o[i] |-> $past(ctl_i[i])); // R10
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b1;
      code_o    <= '0;
      bad_ctl_o <= '0;
    end else begin
      rd_q      <= rd_chain[LANES];
      code_o    <= code_d;
      bad_ctl_o <= lane_bad;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (code_o == '0 && bad_ctl_o == '0)); // R1
  AST_RESET_NEG: assert property (@(posedge clk)
    rst |=> rd_q); // R1
  AST_STORED_FROM_TOP: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rd_q == $past(rd_chain[LANES]))); // R5

  logic unused_ok;
  assign unused_ok = ^DATA_W;
endmodule

// File: tb/tb_enc8b10b_lanes.sv
module tb_enc8b10b_lanes;
  localparam int LANES = 4;
  localparam int DW = LANES * 8;
  localparam int CW = LANES * 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0]    din  = '0;
  logic [LANES-1:0] ctl  = '0, frc = '0, fval = '0;
  logic [CW-1:0]    code;
  logic [LANES-1:0] bad;

  int checks = 0, errors = 0;
  logic model_neg = 1'b1;
  logic [CW-1:0]    prev_code = '0;
  logic [LANES-1:0] prev_bad = '0;
  bit done = 0;

  always #10 clk = ~clk;

  enc8b10b_lanes #(.LANES(LANES)) dut (
    .clk(clk), .rst(rst), .data_i(din), .ctl_i(ctl), .frc_i(frc), .fval_i(fval),
    .code_o(code), .bad_ctl_o(bad)
  );

  logic [5:0] t6 [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
    6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100,
    6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010,
    6'b011010, 6'b111010, 6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
    6'b011110, 6'b101011};
  logic [3:0] t4 [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
  logic [7:0] klist [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                             8'hF7, 8'hFB, 8'hFD, 8'hFE};

  function automatic bit legal_k(input logic [7:0] b);
    return b[4:0] == 5'd28 || b == 8'hF7 || b == 8'hFB || b == 8'hFD || b == 8'hFE;
  endfunction

  // behavioural reference: pick each sub-block by running disparity (1 = negative)
  function automatic void ref_enc(input logic [7:0] b, input bit k, input bit s_neg,
                                  output logic [9:0] cw, output bit e_neg);
    int x, y, n6, n4;
    bit neg, alt, k28;
    logic [5:0] a6;
    logic [3:0] a4;
    x = b[4:0]; y = b[7:5]; neg = s_neg; k28 = k && x == 28;
    a6 = k28 ? 6'b001111 : t6[x];
    n6 = $countones(a6);
    if (n6 != 3 || a6 == 6'b111000) a6 = neg ? a6 : ~a6;
    if (n6 != 3) neg = !neg;
    alt = (y == 7) && (k || (neg && (x == 17 || x == 18 || x == 20)) ||
                       (!neg && (x == 11 || x == 13 || x == 14)));
    a4 = alt ? 4'b0111 : t4[y];
    n4 = $countones(a4);
    if (k28 && (y == 1 || y == 2 || y == 5 || y == 6)) a4 = s_neg ? a4 : ~a4;
    else if (n4 != 2 || y == 3) a4 = neg ? a4 : ~a4;
    if (n4 != 2) neg = !neg;
    cw = {a6, a4};
    e_neg = neg;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; compares the registered result after the next rising edge
  task automatic step(input logic [DW-1:0] d, input logic [LANES-1:0] c, f, v, input string req);
    logic [CW-1:0] ec;
    logic [LANES-1:0] eb;
    logic [9:0] cw;
    bit neg, s, en;
    din = d; ctl = c; frc = f; fval = v;
    neg = model_neg;
    for (int i = 0; i < LANES; i++) begin
      s = f[i] ? v[i] : neg;
      ref_enc(d[i*8 +: 8], c[i] && legal_k(d[i*8 +: 8]), s, cw, en);
      ec[i*10 +: 10] = cw;
      eb[i] = c[i] && !legal_k(d[i*8 +: 8]);
      neg = en;
    end
    model_neg = neg;
    #1;
    check(code === prev_code && bad === prev_bad, "R2", {24'd0, code}, {24'd0, prev_code});
    @(posedge clk); #1;
    check(code === ec, req, {24'd0, code}, {24'd0, ec});
    check(bad === eb, req, {60'd0, bad}, {60'd0, eb});
    prev_code = ec; prev_bad = eb;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(code === '0 && bad === '0, "R1", {24'd0, code}, 64'd0);
    rst = 1'b0;
    // R1 R9 R5: four K28.5 from negative start
    step({4{8'hBC}}, 4'hF, 4'h0, 4'h0, "R5");
    check(code === {10'h305, 10'h0FA, 10'h305, 10'h0FA}, "R9", {24'd0, code},
          {24'd0, 10'h305, 10'h0FA, 10'h305, 10'h0FA});
    // R3: D21.5 is balanced everywhere
    step({4{8'hB5}}, 4'h0, 4'h0, 4'h0, "R3");
    check(code === {4{10'h2AA}}, "R3", {24'd0, code}, {24'd0, {4{10'h2AA}}});
    // R11: D17.7 from negative
    step({8'hB5, 8'hB5, 8'hB5, 8'hF1}, 4'h0, 4'h0, 4'h0, "R11");
    check(code[9:0] === 10'h237, "R11", {54'd0, code[9:0]}, 64'h237);
    // R10: illegal control byte from positive disparity
    step({8'hB5, 8'hB5, 8'hB5, 8'hFF}, 4'h1, 4'h0, 4'h0, "R10");
    check(code[9:0] === 10'h14E && bad === 4'h1, "R10", {50'd0, bad, code[9:0]}, {50'd0, 4'h1, 10'h14E});
    // R7: lane 0 forced positive
    step({4{8'hBC}}, 4'hF, 4'h1, 4'h0, "R7");
    check(code === {10'h0FA, 10'h305, 10'h0FA, 10'h305}, "R7", {24'd0, code},
          {24'd0, 10'h0FA, 10'h305, 10'h0FA, 10'h305});
    // R6: all forced negative
    step({4{8'hBC}}, 4'hF, 4'hF, 4'hF, "R6");
    check(code === {4{10'h0FA}}, "R6", {24'd0, code}, {24'd0, {4{10'h0FA}}});
    // R8: continue from the forced top lane's ending (positive)
    step({4{8'hBC}}, 4'hF, 4'h0, 4'h0, "R8");
    check(code === {10'h0FA, 10'h305, 10'h0FA, 10'h305}, "R8", {24'd0, code},
          {24'd0, 10'h0FA, 10'h305, 10'h0FA, 10'h305});
    // R3 R4: every data byte, twice to reach both polarities in each lane
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 256; b += LANES)
        step({8'(b + 3), 8'(b + 2), 8'(b + 1), 8'(b)}, 4'h0, 4'h0, 4'h0, "R3");
    // R9: every legal control byte in every lane from both polarities
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 12; k++)
        step({4{klist[k]}}, 4'hF, {3'b000, r[0]}, 4'h0, "R9");
    // R10: all illegal control bytes in lane 1
    for (int b = 0; b < 256; b++)
      if (!legal_k(8'(b))) step({8'h00, 8'h00, 8'(b), 8'h00}, 4'h2, 4'h0, 4'h0, "R10");
    // R11: alternate x.7 candidates from both polarities
    for (int r = 0; r < 8; r++)
      step({8'hEB, 8'hF1, 8'hED, 8'hF4}, 4'h0, 4'(r), 4'(r >> 1), "R11");
    // R6 R7 R8 R5: random mix
    for (int n = 0; n < 3000; n++) begin
      logic [DW-1:0] d;
      logic [LANES-1:0] c;
      d = $urandom; c = $urandom;
      for (int i = 0; i < LANES; i++)
        if (c[i] && ($urandom % 6 != 0)) d[i*8 +: 8] = klist[$urandom % 12];
      step(d, c, 4'($urandom), 4'($urandom), "R8");
    end
    // R1: reset mid-run returns to negative start
    rst = 1'b1;
    @(posedge clk); #1;
    check(code === '0 && bad === '0, "R1", {24'd0, code}, 64'd0);
    @(negedge clk);
    rst = 1'b0; model_neg = 1'b1; prev_code = '0; prev_bad = '0;
    step({4{8'h00}}, 4'h0, 4'h0, 4'h0, "R1");
    check(code[9:0] === 10'h274, "R1", {54'd0, code[9:0]}, 64'h274);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule